// File: doc/BRIEF.md
# Six-Channel Countdown Timer Unit

This block is a register-mapped timer peripheral holding six independent 32-bit countdown timers, organised as three identical pairs. Software drives it through a single-cycle register port: a write strobe with address and data, and a combinational read path. A unit-wide clock-control register gates all counting. A fixed identification register lets software confirm the block is present.

Each timer has four registers: mode, run, reload value and current count. A run-register write starts or stops the timer and can ask for the count to be preset from the reload value. A running timer counts down once per clock. When it has reached zero, the next clock refills it from the reload value and latches a pending flag for that timer. Three unit-wide registers deal with interrupts. The first masks the pending flags onto six interrupt outputs. The second holds per-timer interrupt control bits. The third exposes the pending flags, and software clears them by writing ones.

Top module: `sextet_timer_unit`

## Requirements
- R1: Reset state. After reset the clock-control register reads 0x00000001 (unit disabled). Every timer register reads 0, the enable, control and pending registers read 0, and all interrupt outputs are low.
- R2: Address 0x08 always reads 0x00005900, which is the identification byte 0x59 in bits 15:8. Writes to that address change nothing.
- R3: The clock-control register at 0x00 keeps only bit 0 (disable), bit 4 (leave suspend) and bit 8 (run mode), so it reads back as the written value AND 0x111. Timers count only while bit 0 is 0 and bit 8 is 1.
- R4: The registers of timer n (0..5) start at base = 0x10 + (n/2)*0x20 + (n%2)*4. Mode is at base, run at base+0x08, reload at base+0x10 and count at base+0x18. A write to one timer leaves the registers of every other timer unchanged.
- R5: The mode register keeps only bits 2, 6, 7, 8 and 10. It reads back as the written value AND 0x5C4.
- R6: In the run register, bit 0 starts the timer and bit 2 requests a preset. A pending preset reads back in bit 2 until the next clock. At that clock the count takes the reload value and bit 2 returns to 0. The preset happens even while the unit is disabled.
- R7: While a timer runs and the unit is enabled, its count drops by one per clock. On the clock after the count has reached 0, the count takes the reload value and pending bit n is set. A reload value of R therefore gives a period of R+1 clocks.
- R8: Writing 0 to the run register stops the timer. The count then holds its value.
- R9: The count register is read-only, and writes to it are ignored.
- R10: The pending register at 0xFC holds bit n for timer n. Writing 1 to a bit clears it and writing 0 leaves it alone. If an expiry and a clear arrive on the same clock, the expiry wins.
- R11: The enable register at 0xF4 and the control register at 0xF8 each hold 6 bits (bit n is timer n). Output irq_out[n] is pending bit n AND enable bit n. A pending bit is set even when its enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational; 0 for unmapped addresses |
| irq_out | output | 6 | Per-timer interrupt, pending AND enable |

## Verification
The assertions assume the register port raises at most one write per clock and that each write lasts exactly one clock. They also assume the addresses are word aligned, so no address lands between two mapped registers. The bench drives every write for one clock, starting and ending on a falling edge, and uses only word-aligned addresses taken from the map in R4. The bench never starts a clear of a pending bit while that timer could expire, so the same-clock priority of R10 is covered only by the assertions.

// File: rtl/stu_pkg.sv
package stu_pkg;
  localparam logic [31:0] ID_VALUE   = 32'h0000_5900;
  localparam logic [31:0] CLKCTL_MSK = 32'h0000_0111;
  localparam logic [31:0] MODE_MSK   = 32'h0000_05C4;
  localparam int ADR_CLKCTL = 'h00;
  localparam int ADR_ID     = 'h08;
  localparam int ADR_IEN    = 'hF4;
  localparam int ADR_ICTL   = 'hF8;
  localparam int ADR_IPEND  = 'hFC;
  localparam int OFS_MODE = 'h00;
  localparam int OFS_RUN  = 'h08;
  localparam int OFS_RLD  = 'h10;
  localparam int OFS_CNT  = 'h18;
  localparam int CLKCTL_DIS = 0;
  localparam int CLKCTL_RUN = 8;
  localparam int RUN_GO = 0;
  localparam int RUN_RL = 2;

  // Pairs share a 0x20 window; the second timer of a pair sits 4 bytes up.
  function automatic int chan_base(input int idx);
    return 'h10 + (idx / 2) * 'h20 + (idx % 2) * 4;
  endfunction
endpackage

// File: rtl/stu_chan.sv
module stu_chan #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_en,
  input  logic              wr_mode,
  input  logic              wr_run,
  input  logic              wr_rld,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] run_rd,
  output logic [CNT_W-1:0]  rld_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              expire
);
  import stu_pkg::*;

  logic              go_q, go_d;
  logic              rl_q, rl_d;
  logic [DATA_W-1:0] mode_d;
  logic [CNT_W-1:0]  rld_d, cnt_d;
  logic              active, cnt_en;

  always_comb begin
    mode_d = wr_mode ? (wdata & DATA_W'(MODE_MSK)) : mode_q;
    go_d   = wr_run ? wdata[RUN_GO] : go_q;
    rl_d   = wr_run ? wdata[RUN_RL] : 1'b0;
    rld_d  = wr_rld ? wdata[CNT_W-1:0] : rld_q;
    active = go_q & tick_en;
    cnt_en = rl_q | active;
    expire = 1'b0;
    cnt_d  = cnt_q;
    if (rl_q) begin
      cnt_d = rld_q;
    end else if (active) begin
      if (cnt_q == '0) begin
        cnt_d  = rld_q;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    run_rd         = '0;
    run_rd[RUN_GO] = go_q;
    run_rd[RUN_RL] = rl_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      go_q   <= 1'b0;
      rl_q   <= 1'b0;
      rld_q  <= '0;
    end else begin
      mode_q <= mode_d;
      go_q   <= go_d;
      rl_q   <= rl_d;
      rld_q  <= rld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_preset_load_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    rl_q |=> (cnt_q == $past(rld_q)));
  assert_preset_clear_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rl_q && !wr_run) |=> !rl_q);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rl_q && !(go_q && tick_en)) |=> $stable(cnt_q));
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_en && !rl_q) |=> $stable(cnt_q));
  assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rl_q && go_q && tick_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/stu_irq.sv
module stu_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic         wr_ctl,
  input  logic         wr_pend,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] set,
  output logic [N-1:0] en_q,
  output logic [N-1:0] ctl_q,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] irq
);
  logic [N-1:0] en_d, ctl_d, pend_d, clr;

  always_comb begin
    clr    = wr_pend ? wdata : '0;
    pend_d = (pend_q & ~clr) | set;
    en_d   = wr_en  ? wdata : en_q;
    ctl_d  = wr_ctl ? wdata : ctl_q;
    irq    = pend_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ctl_q  <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      set[i] |=> pend_q[i]);
    assert_pend_w1c_R10: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_pend && wdata[i] && !set[i]) |=> !pend_q[i]);
    assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
      (pend_q[i] && !(wr_pend && wdata[i])) |=> pend_q[i]);
  end
endmodule

// File: rtl/sextet_timer_unit.sv
module sextet_timer_unit #(
  parameter int N_TMR  = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  irq_out
);
  import stu_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync[SYNC_STAGES-1];

  logic [DATA_W-1:0] clkctl_q, clkctl_d;
  logic              clkctl_we, unit_on;

  always_comb begin
    clkctl_we = bus_wr && (bus_addr == ADDR_W'(ADR_CLKCTL));
    clkctl_d  = clkctl_we ? (bus_wdata & DATA_W'(CLKCTL_MSK)) : clkctl_q;
    unit_on   = !clkctl_q[CLKCTL_DIS] && clkctl_q[CLKCTL_RUN];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) clkctl_q <= DATA_W'(1);
    else         clkctl_q <= clkctl_d;
  end

  logic [DATA_W-1:0] mode_v [N_TMR];
  logic [DATA_W-1:0] run_v  [N_TMR];
  logic [CNT_W-1:0]  rld_v  [N_TMR];
  logic [CNT_W-1:0]  cnt_v  [N_TMR];
  logic [N_TMR-1:0]  expire_v;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam int BASE = chan_base(i);
    logic hit_mode, hit_run, hit_rld;
    assign hit_mode = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_MODE));
    assign hit_run  = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_RUN));
    assign hit_rld  = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_RLD));

    stu_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .tick_en (unit_on),
      .wr_mode (hit_mode),
      .wr_run  (hit_run),
      .wr_rld  (hit_rld),
      .wdata   (bus_wdata),
      .mode_q  (mode_v[i]),
      .run_rd  (run_v[i]),
      .rld_q   (rld_v[i]),
      .cnt_q   (cnt_v[i]),
      .expire  (expire_v[i])
    );
  end

  logic [N_TMR-1:0] ien_q, ictl_q, pend_q;
  logic             wr_ien, wr_ictl, wr_pend;

  assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(ADR_IEN));
  assign wr_ictl = bus_wr && (bus_addr == ADDR_W'(ADR_ICTL));
  assign wr_pend = bus_wr && (bus_addr == ADDR_W'(ADR_IPEND));

  stu_irq #(.N(N_TMR)) u_irq (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_ien),
    .wr_ctl  (wr_ictl),
    .wr_pend (wr_pend),
    .wdata   (bus_wdata[N_TMR-1:0]),
    .set     (expire_v),
    .en_q    (ien_q),
    .ctl_q   (ictl_q),
    .pend_q  (pend_q),
    .irq     (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_CLKCTL)) bus_rdata = clkctl_q;
    if (bus_addr == ADDR_W'(ADR_ID))     bus_rdata = DATA_W'(ID_VALUE);
    if (bus_addr == ADDR_W'(ADR_IEN))    bus_rdata = DATA_W'(ien_q);
    if (bus_addr == ADDR_W'(ADR_ICTL))   bus_rdata = DATA_W'(ictl_q);
    if (bus_addr == ADDR_W'(ADR_IPEND))  bus_rdata = DATA_W'(pend_q);
    for (int i = 0; i < N_TMR; i++) begin
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_MODE)) bus_rdata = mode_v[i];
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_RUN))  bus_rdata = run_v[i];
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_RLD))  bus_rdata = DATA_W'(rld_v[i]);
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_CNT))  bus_rdata = DATA_W'(cnt_v[i]);
    end
  end

  assert_disabled_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> clkctl_q[CLKCTL_DIS]);
endmodule

// File: tb/sim_sextet_timer_unit.sv
`timescale 1ns/1ps
module sim_sextet_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_out;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sextet_timer_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] tbase(input int n);
    return 8'(16 + (n / 2) * 32 + (n % 2) * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 clkctl", 8'h00, 32'h1);
    rd_chk("R1 count5", tbase(5) + 8'h18, 32'h0);
    rd_chk("R1 run0", tbase(0) + 8'h08, 32'h0);
    rd_chk("R1 pend", 8'hFC, 32'h0);
    rd_chk("R1 ien", 8'hF4, 32'h0);
    check("R1 irq", 32'(irq_out), 32'h0);
  endtask

  task automatic t_id_ctl();
    rd_chk("R2 id", 8'h08, 32'h5900);
    wr(8'h08, 32'h0);
    rd_chk("R2 id after write", 8'h08, 32'h5900);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R3 clkctl mask", 8'h00, 32'h111);
  endtask

  task automatic t_map();
    wr(tbase(1) + 8'h18, 32'h1234);
    rd_chk("R9 count write ignored", tbase(1) + 8'h18, 32'h0);
    wr(tbase(1) + 8'h10, 32'hAAAA_0001);
    wr(tbase(4) + 8'h10, 32'h5555_0004);
    rd_chk("R4 reload t1", 8'h24, 32'hAAAA_0001);
    rd_chk("R4 reload t4", 8'h60, 32'h5555_0004);
    rd_chk("R4 reload t0 untouched", 8'h20, 32'h0);
    wr(tbase(3), 32'hFFFF_FFFF);
    rd_chk("R5 mode mask t3", 8'h34, 32'h5C4);
    rd_chk("R4 mode t2 untouched", 8'h30, 32'h0);
  endtask

  task automatic t_halt();
    wr(8'h00, 32'h111);
    wr(8'h64, 32'd5);
    wr(8'h5C, 32'h5);
    tick();
    rd_chk("R6 preset while disabled", 8'h6C, 32'd5);
    tick(); tick();
    rd_chk("R3 no count while disabled", 8'h6C, 32'd5);
    wr(8'h00, 32'h100);
    tick();
    rd_chk("R3 counts when enabled", 8'h6C, 32'd4);
    wr(8'h00, 32'h000);
    tick();
    rd_chk("R3 no count without run mode", 8'h6C, 32'd3);
    wr(8'h5C, 32'h0);
  endtask

  task automatic t_count();
    wr(8'h00, 32'h110);
    wr(8'h40, 32'd3);
    wr(8'h38, 32'h5);
    rd_chk("R6 preset pending", 8'h38, 32'h5);
    tick();
    rd_chk("R6 preset loaded", 8'h48, 32'd3);
    rd_chk("R6 preset bit clears", 8'h38, 32'h1);
    tick();
    rd_chk("R7 dec", 8'h48, 32'd2);
    tick(); tick();
    rd_chk("R7 at zero", 8'h48, 32'd0);
    rd_chk("R7 no pend yet", 8'hFC, 32'h0);
    tick();
    rd_chk("R7 reloaded", 8'h48, 32'd3);
    rd_chk("R7 pend set", 8'hFC, 32'h4);
    check("R11 masked irq", 32'(irq_out), 32'h0);
    wr(8'hF4, 32'h4);
    check("R11 irq on", 32'(irq_out), 32'h4);
    rd_chk("R11 ien", 8'hF4, 32'h4);
    wr(8'h38, 32'h0);
    tick(); tick(); tick();
    rd_chk("R8 stopped count holds", 8'h48, 32'd1);
    wr(8'hFC, 32'hFFFF_FFFB);
    rd_chk("R10 write zero keeps", 8'hFC, 32'h4);
    wr(8'hFC, 32'h4);
    rd_chk("R10 w1c", 8'hFC, 32'h0);
    check("R11 irq off", 32'(irq_out), 32'h0);
    wr(8'hF8, 32'hFFFF_FFFF);
    rd_chk("R11 ictl width", 8'hF8, 32'h3F);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_id_ctl();
    t_map();
    t_halt();
    t_count();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule